// File: doc/BRIEF.md
# Multi-Context Stack Register Cache

This block keeps the topmost entries of a hardware operand stack in on-chip registers, with one independent register set per task context. The core pushes, pops and reads the top of stack of whichever context `ctx_sel` names. Context 0 is the supervisor set and the others are user sets. Nothing is ever refilled from memory. A push never writes memory by itself. Modified entries are copied out in the background over a single write port, and only in cycles where the bus is idle.

Each set is a circular buffer. Cleaning always proceeds upward from the bottom of the set, while new dirty data only enters at the top. For that reason a per-set count of clean entries at the bottom is enough to track the dirty state of every entry. A written entry stays cached and becomes clean.

At most one write is issued per cycle, chosen in this priority order:
- the active user set, once it is nearly full;
- otherwise an inactive dirty user set, the least recently used one first;
- otherwise the supervisor set, and only when the core is also quiet.

A push into a full set overwrites the bottom entry when that entry is clean. If the bottom entry is dirty, the push stalls until the entry has been written out.

Top module: `stack_cache`

## Requirements
- R1: Push stores `push_data` on the stack of context `ctx_sel`, and pop removes the top entry. `tos_data` shows the top entry of the selected context one cycle after a push or pop. Each context keeps its own stack.
- R2: `mem_we` is high only in cycles where `bus_idle` is high, and at most one entry is written per cycle. A push never causes a write of the pushed entry by itself while its set is below the threshold.
- R3: While the active user set holds at least THR = floor(DEPTH*9/10) entries and has a dirty entry, its lowest dirty entry is written out. The write address is ctx*STRIDE + the entry's absolute depth, where the first entry ever pushed has depth 0. The write data is the entry value. The entry stays cached, and `tos_data` is unchanged.
- R4: Dirty inactive user sets are written least recently used first. Selecting a user context makes it the most recently used. After reset the order from least to most recent is NCTX-1 down to 1.
- R5: When both are eligible, a write for the active set's threshold takes precedence over a write for an inactive user set.
- R6: The supervisor set (context 0) is written only in a cycle where `bus_idle` is high, no push or pop is accepted, and no user set is eligible.
- R7: A push into a full set whose bottom entry is clean drops that bottom entry. There is no stall, and the set keeps DEPTH entries.
- R8: A push into a full set whose bottom entry is dirty raises `stall` in the same cycle and leaves the stack unchanged. The push completes in the first cycle after the bottom entry has been written out.
- R9: A pop on an empty active set leaves the state unchanged. It raises `underflow` for exactly the following cycle.
- R10: `set_clean[c]` is high exactly when context c holds no dirty entry.
- R11: When push and pop are both high in the same cycle, only the pop acts.
- R12: After reset all sets are empty and clean, and `stall`, `underflow` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ctx_sel | input | CXW | Active context (0 = supervisor) |
| push | input | 1 | Push request |
| pop | input | 1 | Pop request |
| push_data | input | W | Value to push |
| tos_data | output | W | Top entry of the active context |
| stall | output | 1 | Push held back: the set is full and its bottom entry is dirty |
| underflow | output | 1 | One-cycle flag after a pop on an empty set |
| bus_idle | input | 1 | Memory bus free for a write this cycle |
| mem_we | output | 1 | Write strobe |
| mem_addr | output | MAW | Write address |
| mem_wdata | output | W | Write data |
| set_clean | output | NCTX | Per-context no-dirty-entries status |

## Verification
The bench builds the block with DEPTH=8, NCTX=4, W=16 and STRIDE=64, which makes THR equal to 7. With these values a set can be filled, pushed past full, and drained within a few dozen cycles. Four contexts give three user sets, so a least-recently-used order that differs from the index order can be built up. The small depth also makes both full-set cases reachable: the overwrite of a clean bottom entry and the stall on a dirty one. The address checks then confirm how the depth index keeps counting past the circular wrap.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_HOT   = 2'd1,
    SRC_LRU   = 2'd2,
    SRC_SUPER = 2'd3
  } wb_src_e;
endpackage

// File: rtl/stk_set.sv
module stk_set #(
  parameter int W     = 32,
  parameter int DEPTH = 100,
  parameter int AW    = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_en,
  input  logic                         pop_en,
  input  logic                         clean_en,
  input  logic [W-1:0]                 push_data,
  output logic [W-1:0]                 tos,
  output logic [$clog2(DEPTH+1)-1:0]   cnt,
  output logic [$clog2(DEPTH+1)-1:0]   ncl,
  output logic [W-1:0]                 wb_data,
  output logic [AW-1:0]                wb_depth
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] top_q, top_d, top_m1, top_p1, idx;
  logic [CW-1:0] cnt_q, cnt_d, ncl_q, ncl_d, off;
  logic [AW-1:0] sp_q, sp_d;
  logic          full, st_en;

  always_comb begin
    full   = (cnt_q == CW'(DEPTH));
    top_m1 = (top_q == '0) ? PW'(DEPTH - 1) : top_q - 1'b1;
    top_p1 = (top_q == PW'(DEPTH - 1)) ? '0 : top_q + 1'b1;
    off    = cnt_q - ncl_q;
    if (CW'(top_q) >= off) idx = top_q - PW'(off);
    else                   idx = top_q + PW'(CW'(DEPTH) - off);
  end

  assign tos      = mem_q[top_m1];
  assign wb_data  = mem_q[idx];
  assign wb_depth = sp_q - AW'(off);
  assign cnt      = cnt_q;
  assign ncl      = ncl_q;
  assign st_en    = push_en | pop_en | clean_en;

  always_comb begin
    cnt_d = cnt_q;
    ncl_d = ncl_q + CW'(clean_en);
    top_d = top_q;
    sp_d  = sp_q;
    if (pop_en) begin
      top_d = top_m1;
      cnt_d = cnt_q - 1'b1;
      sp_d  = sp_q - 1'b1;
      if (ncl_d > cnt_d) ncl_d = cnt_d;
    end else if (push_en) begin
      top_d = top_p1;
      sp_d  = sp_q + 1'b1;
      if (full) ncl_d = ncl_d - 1'b1;
      else      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= '0;
      cnt_q <= '0;
      ncl_q <= '0;
      sp_q  <= '0;
    end else if (st_en) begin
      top_q <= top_d;
      cnt_q <= cnt_d;
      ncl_q <= ncl_d;
      sp_q  <= sp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_en) mem_q[top_q] <= push_data;
  end

  p_clean_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ncl_q <= cnt_q);
  p_no_dirty_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && full) |-> (ncl_q != '0));
  p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> (cnt_q != '0));
  p_clean_has_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clean_en |-> (ncl_q < cnt_q));
endmodule

// File: rtl/lru_track.sv
module lru_track #(
  parameter int NCTX = 4,
  parameter int CXW  = 2,
  parameter int RKW  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       act_ok,
  input  logic [CXW-1:0]             act,
  output logic [(NCTX-1)*RKW-1:0]    ranks
);
  logic [RKW-1:0] rank_q [1:NCTX-1];
  logic [RKW-1:0] rank_d [1:NCTX-1];
  logic           upd;

  assign upd = act_ok && (act != '0);

  always_comb begin
    for (int c = 1; c < NCTX; c++) begin
      rank_d[c] = rank_q[c];
      if (CXW'(c) == act)                rank_d[c] = '0;
      else if (rank_q[c] < rank_q[act])  rank_d[c] = rank_q[c] + 1'b1;
      ranks[(c-1)*RKW +: RKW] = rank_q[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 1; c < NCTX; c++) rank_q[c] <= RKW'(c - 1);
    end else if (upd) begin
      for (int c = 1; c < NCTX; c++) rank_q[c] <= rank_d[c];
    end
  end
endmodule

// File: rtl/wb_arb.sv
module wb_arb
  import stk_pkg::*;
#(
  parameter int NCTX = 4,
  parameter int CXW  = 2,
  parameter int RKW  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_idle,
  input  logic                     quiet,
  input  logic                     act_ok,
  input  logic [CXW-1:0]           act,
  input  logic [NCTX-1:0]          dirty,
  input  logic [NCTX-1:0]          hot,
  input  logic [(NCTX-1)*RKW-1:0]  ranks,
  output logic                     we,
  output logic [CXW-1:0]           gnt
);
  wb_src_e        src;
  logic           found;
  logic [RKW-1:0] best;
  logic [CXW-1:0] pick;

  always_comb begin
    found = 1'b0;
    best  = '0;
    pick  = '0;
    for (int c = 1; c < NCTX; c++) begin
      if (dirty[c] && !(act_ok && CXW'(c) == act) &&
          (!found || ranks[(c-1)*RKW +: RKW] > best)) begin
        found = 1'b1;
        best  = ranks[(c-1)*RKW +: RKW];
        pick  = CXW'(c);
      end
    end
    src = SRC_NONE;
    gnt = '0;
    if (bus_idle) begin
      if (act_ok && act != '0 && hot[act] && dirty[act]) begin
        src = SRC_HOT;
        gnt = act;
      end else if (found) begin
        src = SRC_LRU;
        gnt = pick;
      end else if (dirty[0] && quiet) begin
        src = SRC_SUPER;
      end
    end
    we = (src != SRC_NONE);
  end

  p_idle_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> bus_idle);
  p_super_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && gnt == '0) |-> (quiet && bus_idle));
  p_grant_dirty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> dirty[gnt]);
endmodule

// File: rtl/stack_cache.sv
module stack_cache #(
  parameter int W      = 32,
  parameter int DEPTH  = 100,
  parameter int NCTX   = 4,
  parameter int STRIDE = 1024,
  parameter int MAW    = 16,
  parameter int CXW    = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CXW-1:0]  ctx_sel,
  input  logic            push,
  input  logic            pop,
  input  logic [W-1:0]    push_data,
  output logic [W-1:0]    tos_data,
  output logic            stall,
  output logic            underflow,
  input  logic            bus_idle,
  output logic            mem_we,
  output logic [MAW-1:0]  mem_addr,
  output logic [W-1:0]    mem_wdata,
  output logic [NCTX-1:0] set_clean
);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int AW  = (STRIDE > 1) ? $clog2(STRIDE) : 1;
  localparam int RKW = (NCTX > 2) ? $clog2(NCTX - 1) : 1;
  localparam int THR = (DEPTH * 9 / 10 > 0) ? DEPTH * 9 / 10 : 1;

  logic [1:0]      rs_q;
  logic            rst_i;
  logic [W-1:0]    tos_a  [NCTX];
  logic [W-1:0]    wbp_a  [NCTX];
  logic [AW-1:0]   wbd_a  [NCTX];
  logic [CW-1:0]   cnt_a  [NCTX];
  logic [CW-1:0]   ncl_a  [NCTX];
  logic [NCTX-1:0] push_en, pop_en, clean_en, dirty, hot;
  logic            act_ok, core_act, we, uf_q, uf_d;
  logic [CXW-1:0]  gnt;
  logic [(NCTX-1)*RKW-1:0] ranks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  assign act_ok = (int'(ctx_sel) < NCTX);

  always_comb begin
    stall = act_ok && push && !pop &&
            (cnt_a[ctx_sel] == CW'(DEPTH)) && (ncl_a[ctx_sel] == '0);
    uf_d  = act_ok && pop && (cnt_a[ctx_sel] == '0);
    for (int c = 0; c < NCTX; c++) begin
      push_en[c]  = act_ok && (ctx_sel == CXW'(c)) && push && !pop && !stall;
      pop_en[c]   = act_ok && (ctx_sel == CXW'(c)) && pop && (cnt_a[c] != '0);
      dirty[c]    = (ncl_a[c] < cnt_a[c]);
      hot[c]      = (cnt_a[c] >= CW'(THR));
      clean_en[c] = we && (gnt == CXW'(c));
    end
    core_act = (|push_en) || (|pop_en);
  end

  for (genvar g = 0; g < NCTX; g++) begin : g_set
    stk_set #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_set (
      .clk(clk), .rst_n(rst_i),
      .push_en(push_en[g]), .pop_en(pop_en[g]), .clean_en(clean_en[g]),
      .push_data(push_data),
      .tos(tos_a[g]), .cnt(cnt_a[g]), .ncl(ncl_a[g]),
      .wb_data(wbp_a[g]), .wb_depth(wbd_a[g])
    );
  end

  lru_track #(.NCTX(NCTX), .CXW(CXW), .RKW(RKW)) u_lru (
    .clk(clk), .rst_n(rst_i), .act_ok(act_ok), .act(ctx_sel), .ranks(ranks)
  );

  wb_arb #(.NCTX(NCTX), .CXW(CXW), .RKW(RKW)) u_arb (
    .clk(clk), .rst_n(rst_i), .bus_idle(bus_idle), .quiet(!core_act),
    .act_ok(act_ok), .act(ctx_sel), .dirty(dirty), .hot(hot),
    .ranks(ranks), .we(we), .gnt(gnt)
  );

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) uf_q <= 1'b0;
    else        uf_q <= uf_d;
  end

  assign tos_data  = tos_a[ctx_sel];
  assign underflow = uf_q;
  assign mem_we    = we;
  assign mem_wdata = wbp_a[gnt];
  assign mem_addr  = MAW'(gnt) * MAW'(STRIDE) + MAW'(wbd_a[gnt]);
  assign set_clean = ~dirty;

  p_underflow_flag_r9: assert property (@(posedge clk) disable iff (!rst_i)
    (act_ok && pop && cnt_a[ctx_sel] == '0) |=> underflow);
  p_stall_no_push_r8: assert property (@(posedge clk) disable iff (!rst_i)
    stall |-> (push_en == '0));
  p_one_clean_r2: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0(clean_en));
endmodule

// File: tb/test_stack_cache.sv
module test_stack_cache;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16, DEPTH = 8, NCTX = 4, STRIDE = 64, MAW = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [1:0]      ctx_sel;
  logic            push, pop, bus_idle;
  logic [W-1:0]    push_data;
  logic [W-1:0]    tos_data, mem_wdata;
  logic            stall, underflow, mem_we;
  logic [MAW-1:0]  mem_addr;
  logic [NCTX-1:0] set_clean;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_cache #(.W(W), .DEPTH(DEPTH), .NCTX(NCTX), .STRIDE(STRIDE), .MAW(MAW)) i_stack_cache (
    .clk(clk), .rst_n(rst_n), .ctx_sel(ctx_sel), .push(push), .pop(pop),
    .push_data(push_data), .tos_data(tos_data), .stall(stall),
    .underflow(underflow), .bus_idle(bus_idle), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .set_clean(set_clean)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic pre();  #(CLK_PERIOD/2 - 1); endtask

  task automatic do_push(input int v);
    push = 1'b1; push_data = W'(v);
    tick();
    push = 1'b0;
  endtask

  task automatic do_pop();
    pop = 1'b1; tick(); pop = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ctx_sel = 2'd1; push = 0; pop = 0; push_data = '0; bus_idle = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R12 clean", int'(set_clean), 'hF);
    chk("R12 stall", int'(stall), 0);
    chk("R12 underflow", int'(underflow), 0);
    chk("R12 mem_we", int'(mem_we), 0);
  endtask

  task automatic t_lifo();
    bus_idle = 1'b1; ctx_sel = 2'd1;
    for (int i = 1; i <= 3; i++) begin
      push = 1'b1; push_data = W'(i);
      pre();
      chk("R2 push without write", int'(mem_we), 0);
      tick();
      chk("R1 tos after push", int'(tos_data), i);
    end
    push = 1'b0;
    do_pop();
    chk("R1 tos after pop", int'(tos_data), 2);
    bus_idle = 1'b0;
    ctx_sel = 2'd2;
    do_push('hA0);
    chk("R1 other context", int'(tos_data), 'hA0);
    ctx_sel = 2'd1; tick();
    chk("R1 context kept", int'(tos_data), 2);
  endtask

  task automatic t_lru();
    ctx_sel = 2'd3; tick();
    chk("R10 dirty status", int'(set_clean), 'b1001);
    bus_idle = 1'b1;
    pre();
    chk("R4 first lru we", int'(mem_we), 1);
    chk("R4 first lru addr", int'(mem_addr), 128);
    chk("R4 first lru data", int'(mem_wdata), 'hA0);
    tick(); pre();
    chk("R4 second lru addr", int'(mem_addr), 64);
    chk("R4 second lru data", int'(mem_wdata), 1);
    tick(); pre();
    chk("R4 third lru addr", int'(mem_addr), 65);
    tick(); pre();
    chk("R2 nothing left", int'(mem_we), 0);
    tick();
    chk("R10 all clean", int'(set_clean), 'hF);
  endtask

  task automatic t_threshold();
    bus_idle = 1'b0;
    ctx_sel = 2'd1; do_push('h11);
    ctx_sel = 2'd3;
    for (int i = 0; i < 7; i++) do_push('h30 + i);
    bus_idle = 1'b1;
    for (int k = 0; k < 7; k++) begin
      pre();
      chk("R5 R3 hot we", int'(mem_we), 1);
      chk("R5 R3 hot addr", int'(mem_addr), 192 + k);
      chk("R3 hot data", int'(mem_wdata), 'h30 + k);
      tick();
    end
    pre();
    chk("R5 then lru addr", int'(mem_addr), 66);
    chk("R5 then lru data", int'(mem_wdata), 'h11);
    tick();
    bus_idle = 1'b0;
    chk("R3 entry kept", int'(tos_data), 'h36);
    chk("R3 all clean", int'(set_clean), 'hF);
  endtask

  task automatic t_drop();
    ctx_sel = 2'd3; bus_idle = 1'b0;
    do_push('h37);
    push = 1'b1; push_data = 'h38;
    pre();
    chk("R7 no stall on clean bottom", int'(stall), 0);
    tick(); push = 1'b0;
    chk("R7 tos", int'(tos_data), 'h38);
    for (int i = 0; i < 8; i++) begin
      chk("R7 contents", int'(tos_data), 'h38 - i);
      do_pop();
      chk("R9 no underflow", int'(underflow), 0);
    end
    do_pop();
    chk("R7 R9 bottom was dropped", int'(underflow), 1);
  endtask

  task automatic t_stall();
    ctx_sel = 2'd0; bus_idle = 1'b1;
    repeat (3) tick();
    chk("R10 drained", int'(set_clean), 'hF);
    bus_idle = 1'b0;
    for (int i = 0; i < 8; i++) do_push('h50 + i);
    push = 1'b1; push_data = 'h58;
    for (int k = 0; k < 2; k++) begin
      pre();
      chk("R8 stall", int'(stall), 1);
      tick();
      chk("R8 state held", int'(tos_data), 'h57);
    end
    bus_idle = 1'b1;
    pre();
    chk("R6 super write quiet", int'(mem_we), 1);
    chk("R6 super addr", int'(mem_addr), 0);
    chk("R6 super data", int'(mem_wdata), 'h50);
    chk("R8 still stalled", int'(stall), 1);
    tick(); pre();
    chk("R8 stall released", int'(stall), 0);
    chk("R6 no super write on push", int'(mem_we), 0);
    tick(); push = 1'b0;
    chk("R8 push done", int'(tos_data), 'h58);
    pre();
    chk("R6 super resumes", int'(mem_we), 1);
    chk("R6 super depth", int'(mem_addr), 1);
    chk("R6 super data2", int'(mem_wdata), 'h51);
    tick();
    bus_idle = 1'b0;
  endtask

  task automatic t_underflow();
    ctx_sel = 2'd1;
    chk("R1 tos ctx1", int'(tos_data), 'h11);
    do_pop(); chk("R1 pop a", int'(tos_data), 2);
    do_pop(); chk("R1 pop b", int'(tos_data), 1);
    do_pop(); chk("R9 no flag", int'(underflow), 0);
    do_pop(); chk("R9 flag", int'(underflow), 1);
    tick();   chk("R9 single cycle", int'(underflow), 0);
    chk("R9 state kept", int'(set_clean), 'hE);
    do_push('h77);
    chk("R1 push after empty", int'(tos_data), 'h77);
    push = 1'b1; pop = 1'b1; push_data = 'h78;
    tick(); push = 1'b0; pop = 1'b0;
    chk("R11 pop only flag", int'(underflow), 0);
    do_pop();
    chk("R11 push ignored", int'(underflow), 1);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_lifo();
    t_lru();
    t_threshold();
    t_drop();
    t_stall();
    t_underflow();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule